// File: doc/BRIEF.md
# Output-Buffered Switch Port Timing Model

This block models the timing of the output side of a packet switch without touching any payload. A separate forwarding model hands it one packet descriptor per cycle: a destination output, a length in bytes and a tag. For each output the block keeps a first-in-first-out queue of descriptors with a byte budget. A descriptor either joins its output's queue or is discarded at once, and each queued descriptor later leaves with a single-cycle release strobe that carries its tag.

The hold time of a packet comes from three run-time settings: the link speed, given as cycles per byte with four fraction bits; a fixed link latency in cycles; and the byte capacity of each output queue. All three are plain inputs and can change between packets. Only the packet at the head of a queue counts down. Packets on one output therefore drain one after another, and the queue fills when many sources aim at the same output. This is the overflow behind throughput collapse with many senders. Discards raise a strobe and advance a saturating counter.

Top module: `swtm_switch_timing`

## Requirements
- R1: After synchronous reset, no release strobe and no drop strobe is raised, and `drop_count` reads 0.
- R2: The hold time is D = max(1, ceil(len × cfg_cyc_per_byte / 16) + cfg_link_delay). Here cfg_cyc_per_byte is in units of 1/16 cycle per byte. A packet accepted in cycle n into an empty queue raises `rel_valid[p]` with its tag on `rel_id[p*8 +: 8]` in cycle n+D.
- R3: Packets on one output leave in arrival order. Each strobe lasts one cycle. A packet's countdown starts when the packet ahead of it is released, so it leaves D cycles after that release.
- R4: Outputs are independent. Each has its own queue, byte occupancy and countdown.
- R5: An arrival is accepted only if the output's byte occupancy plus its length is at most `cfg_buf_bytes`. A packet that fills the budget exactly is accepted. Occupancy grows by a packet's length on acceptance and shrinks by that length on its release.
- R6: A refused arrival raises `drop_strobe` in its arrival cycle, is never released, and adds one to `drop_count`.
- R7: An output holds at most DEPTH (default 8) descriptors. An arrival that would exceed this is dropped even if bytes remain.
- R8: When an output releases in the same cycle that an arrival for it is presented, the released bytes and slot are freed before the acceptance check.
- R9: `drop_count` is DROP_W (default 8) bits wide and stops at its maximum value (255) instead of wrapping.
- R10: Settings are read at run time. The hold time is fixed from the settings in the arrival cycle, so later changes to the settings leave it unchanged. A new byte budget applies to the next arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cyc_per_byte | input | 8 | Link serialization cost, cycles per byte with 4 fraction bits |
| cfg_link_delay | input | 8 | Fixed link latency in cycles |
| cfg_buf_bytes | input | 19 | Byte capacity of each output queue |
| arr_valid | input | 1 | Descriptor present this cycle |
| arr_port | input | 1 | Destination output index |
| arr_len | input | 11 | Packet length in bytes |
| arr_id | input | 8 | Descriptor tag |
| rel_valid | output | 2 | Per-output release strobe |
| rel_id | output | 16 | Per-output released tag, 8 bits per output |
| drop_strobe | output | 1 | Arrival refused this cycle |
| drop_count | output | 8 | Saturating count of refused arrivals |

## Verification
If the byte occupancy is stale or leaks, acceptance goes wrong. An arrival near the budget then draws a wrong drop strobe in its own cycle, and a dropped tag goes missing from the later release log. If a head countdown is loaded or reloaded wrongly, the release cycle of that packet moves, along with every later packet on that output, and this shows at the first release after the fault. Release-first ordering shows only when an arrival lands in the exact cycle of a release, so the tests place arrivals at that cycle and at the cycle before it.

// File: rtl/swtm_pkg.sv
package swtm_pkg;

    parameter int LEN_W    = 11;
    parameter int ID_W     = 8;
    parameter int CPB_W    = 8;
    parameter int CPB_FRAC = 4;
    parameter int LINK_W   = 8;
    parameter int BUF_W    = 19;

    localparam int PROD_W = LEN_W + CPB_W;
    localparam int SER_W  = PROD_W + 1 - CPB_FRAC;
    localparam int DLY_W  = ((SER_W > LINK_W) ? SER_W : LINK_W) + 1;

    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [ID_W-1:0]   id_t;
    typedef logic [CPB_W-1:0]  cpb_t;
    typedef logic [LINK_W-1:0] link_t;
    typedef logic [BUF_W-1:0]  buf_t;
    typedef logic [DLY_W-1:0]  dly_t;

    typedef struct packed {
        id_t  id;
        len_t len;
        dly_t dly;
    } desc_t;

    // Serialization rounded up, plus wire latency, never below one cycle.
    function automatic dly_t total_delay(len_t len, cpb_t cpb, link_t link);
        logic [PROD_W-1:0] prod;
        logic [PROD_W:0]   rnd;
        logic [SER_W-1:0]  ser;
        dly_t              tot;
        prod = {{CPB_W{1'b0}}, len} * {{LEN_W{1'b0}}, cpb};
        rnd  = {1'b0, prod} + (PROD_W+1)'((1 << CPB_FRAC) - 1);
        ser  = SER_W'(rnd >> CPB_FRAC);
        tot  = DLY_W'(ser) + DLY_W'(link);
        if (tot == '0) tot = DLY_W'(1);
        return tot;
    endfunction

endpackage

// File: rtl/swtm_delay_calc.sv
module swtm_delay_calc
    import swtm_pkg::*;
(
    input  len_t  len,
    input  cpb_t  cpb,
    input  link_t link,
    output dly_t  dly
);
    assign dly = total_delay(len, cpb, link);
endmodule

// File: rtl/swtm_drop_counter.sv
module swtm_drop_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (hit && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    assert_drop_step_R9: assert property (@(posedge clk) disable iff (rst)
        (hit && cnt != TOP) |=> cnt == $past(cnt) + 1'b1)
        else $error("drop count did not advance");

    assert_drop_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!hit || cnt == TOP) |=> $stable(cnt))
        else $error("drop count moved without a drop or wrapped");
endmodule

// File: rtl/swtm_port_queue.sv
module swtm_port_queue
    import swtm_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  desc_t req_desc,
    input  buf_t  cfg_buf,
    output logic  accept,
    output logic  rel_valid,
    output id_t   rel_id
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    desc_t            slots [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count, count_after;
    buf_t             occ, occ_after;
    dly_t             head_cnt;
    logic             pop;
    desc_t            head, next_head;
    logic [BUF_W:0]   need;

    always_comb begin
        head        = slots[rd_ptr];
        next_head   = slots[rd_ptr + 1'b1];
        pop         = (count != '0) && (head_cnt == DLY_W'(1));
        // Release is credited before the new arrival is judged.
        occ_after   = pop ? occ - BUF_W'(head.len) : occ;
        count_after = count - CW'(pop);
        need        = {1'b0, occ_after} + (BUF_W+1)'(req_desc.len);
        accept      = req && (need <= {1'b0, cfg_buf})
                          && (count_after < CW'(DEPTH));
    end

    assign rel_valid = pop;
    assign rel_id    = head.id;

    always_ff @(posedge clk) begin
        if (accept)
            slots[wr_ptr] <= req_desc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            count    <= '0;
            occ      <= '0;
            head_cnt <= '0;
        end else begin
            if (pop)    rd_ptr <= rd_ptr + 1'b1;
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            count <= count_after + CW'(accept);
            occ   <= accept ? occ_after + BUF_W'(req_desc.len) : occ_after;
            if (count_after != '0)
                head_cnt <= pop ? next_head.dly : head_cnt - 1'b1;
            else if (accept)
                head_cnt <= req_desc.dly;
            else
                head_cnt <= '0;
        end
    end

    assert_empty_no_bytes_R5: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> (occ == '0))
        else $error("bytes held by an empty queue");

    assert_head_armed_R2: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (head_cnt != '0))
        else $error("queued head has no countdown");

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH))
        else $error("queue exceeded its slot count");

    assert_release_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && !accept) |=> count == $past(count) - 1'b1)
        else $error("release did not remove an entry");
endmodule

// File: rtl/swtm_switch_timing.sv
module swtm_switch_timing
    import swtm_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DEPTH     = 8,
    parameter int DROP_W    = 8,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CPB_W-1:0]          cfg_cyc_per_byte,
    input  logic [LINK_W-1:0]         cfg_link_delay,
    input  logic [BUF_W-1:0]          cfg_buf_bytes,
    input  logic                      arr_valid,
    input  logic [PORT_W-1:0]         arr_port,
    input  logic [LEN_W-1:0]          arr_len,
    input  logic [ID_W-1:0]           arr_id,
    output logic [NUM_PORTS-1:0]      rel_valid,
    output logic [NUM_PORTS*ID_W-1:0] rel_id,
    output logic                      drop_strobe,
    output logic [DROP_W-1:0]         drop_count
);
    desc_t                in_desc;
    dly_t                 in_dly;
    logic [NUM_PORTS-1:0] accepted;

    swtm_delay_calc u_dly (
        .len  (arr_len),
        .cpb  (cfg_cyc_per_byte),
        .link (cfg_link_delay),
        .dly  (in_dly)
    );

    always_comb begin
        in_desc.id  = arr_id;
        in_desc.len = arr_len;
        in_desc.dly = in_dly;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic req_p;
        assign req_p = arr_valid && (arr_port == PORT_W'(p));
        swtm_port_queue #(.DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst       (rst),
            .req       (req_p),
            .req_desc  (in_desc),
            .cfg_buf   (cfg_buf_bytes),
            .accept    (accepted[p]),
            .rel_valid (rel_valid[p]),
            .rel_id    (rel_id[p*ID_W +: ID_W])
        );
    end

    assign drop_strobe = arr_valid && (accepted == '0);

    swtm_drop_counter #(.W(DROP_W)) u_drops (
        .clk (clk),
        .rst (rst),
        .hit (drop_strobe),
        .cnt (drop_count)
    );

    assert_single_accept_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(accepted))
        else $error("one arrival taken by several outputs");
endmodule

// File: tb/swtm_switch_timing_tb_top.sv
module swtm_switch_timing_tb_top;
    localparam int DEPTH = 8;
    localparam int SAT   = 255;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_cpb  = 8'd16;
    logic [7:0]  cfg_link = 8'd0;
    logic [18:0] cfg_buf  = 19'd1000;
    logic        arr_valid = 1'b0;
    logic [0:0]  arr_port  = 1'b0;
    logic [10:0] arr_len   = '0;
    logic [7:0]  arr_id    = '0;
    logic [1:0]  rel_valid;
    logic [15:0] rel_id;
    logic        drop_strobe;
    logic [7:0]  drop_count;

    swtm_switch_timing dut_i (
        .clk(clk), .rst(rst),
        .cfg_cyc_per_byte(cfg_cpb), .cfg_link_delay(cfg_link), .cfg_buf_bytes(cfg_buf),
        .arr_valid(arr_valid), .arr_port(arr_port), .arr_len(arr_len), .arr_id(arr_id),
        .rel_valid(rel_valid), .rel_id(rel_id),
        .drop_strobe(drop_strobe), .drop_count(drop_count)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int fails = 0;
    int exp_drops = 0;
    int last_arr = 0;
    int rel_c [2][64];
    int rel_i [2][64];
    int rel_n [2];

    always @(negedge clk) begin
        #2;
        for (int p = 0; p < 2; p++) begin
            if (rel_valid[p] && rel_n[p] < 64) begin
                rel_c[p][rel_n[p]] = cyc;
                rel_i[p][rel_n[p]] = int'(rel_id[p*8 +: 8]);
                rel_n[p] = rel_n[p] + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rel_at(int port, int id);
        for (int k = 0; k < rel_n[port]; k++)
            if (rel_i[port][k] == id) return rel_c[port][k];
        return -1;
    endfunction

    function automatic int want_dly(int len, int cpb, int link);
        int d;
        d = (len * cpb + 15) / 16 + link;
        return (d < 1) ? 1 : d;
    endfunction

    task automatic clear_log();
        rel_n[0] = 0;
        rel_n[1] = 0;
    endtask

    task automatic send(int port, int len, int id, bit exp_drop, string req);
        @(negedge clk);
        arr_valid = 1'b1;
        arr_port  = port[0:0];
        arr_len   = len[10:0];
        arr_id    = id[7:0];
        #2;
        last_arr = cyc;
        chk(drop_strobe == exp_drop, req, "drop strobe", int'(drop_strobe), int'(exp_drop));
        if (exp_drop && exp_drops < SAT) exp_drops++;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            arr_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        #2;
        chk(rel_valid == 2'b00, "R1", "release after reset", int'(rel_valid), 0);
        chk(drop_strobe == 1'b0, "R1", "drop after reset", int'(drop_strobe), 0);
        chk(drop_count == 8'd0, "R1", "drop count after reset", int'(drop_count), 0);
    endtask

    task automatic t_delay();
        int a;
        clear_log();
        cfg_buf = 19'd1000; cfg_cpb = 8'd16; cfg_link = 8'd3;
        send(0, 10, 1, 0, "R2"); a = last_arr; idle(20);
        chk(rel_at(0, 1) == a + want_dly(10, 16, 3), "R2", "whole-cycle rate", rel_at(0, 1), a + 13);
        cfg_cpb = 8'd8; cfg_link = 8'd0;
        send(1, 5, 2, 0, "R2"); a = last_arr; idle(10);
        chk(rel_at(1, 2) == a + 3, "R2", "half-cycle rate rounds up", rel_at(1, 2), a + 3);
        cfg_cpb = 8'd20; cfg_link = 8'd2;
        send(0, 7, 3, 0, "R2"); a = last_arr; idle(20);
        chk(rel_at(0, 3) == a + 11, "R2", "fractional rate", rel_at(0, 3), a + 11);
        cfg_cpb = 8'd16; cfg_link = 8'd0;
        send(1, 0, 4, 0, "R2"); a = last_arr; idle(5);
        chk(rel_at(1, 4) == a + 1, "R2", "minimum one cycle", rel_at(1, 4), a + 1);
    endtask

    task automatic t_fifo();
        int a, r1, r2, r3;
        clear_log();
        cfg_cpb = 8'd16; cfg_link = 8'd2;
        send(0, 4, 10, 0, "R3"); a = last_arr;
        send(0, 6, 11, 0, "R3");
        send(0, 3, 12, 0, "R3");
        idle(40);
        r1 = a + 6; r2 = r1 + 8; r3 = r2 + 5;
        chk(rel_at(0, 10) == r1, "R3", "first release", rel_at(0, 10), r1);
        chk(rel_at(0, 11) == r2, "R3", "second after first", rel_at(0, 11), r2);
        chk(rel_at(0, 12) == r3, "R3", "third after second", rel_at(0, 12), r3);
        chk(rel_n[0] == 3, "R3", "one-cycle strobes", rel_n[0], 3);
    endtask

    task automatic t_ports();
        int a;
        clear_log();
        cfg_cpb = 8'd16; cfg_link = 8'd0;
        send(0, 30, 20, 0, "R4"); a = last_arr;
        send(1, 5, 21, 0, "R4");
        idle(40);
        chk(rel_at(1, 21) == a + 6, "R4", "short port not blocked", rel_at(1, 21), a + 6);
        chk(rel_at(0, 20) == a + 30, "R4", "long port own timing", rel_at(0, 20), a + 30);
    endtask

    task automatic t_bytes();
        int a;
        clear_log();
        cfg_buf = 19'd100; cfg_cpb = 8'd16; cfg_link = 8'd200;
        send(0, 60, 30, 0, "R5"); a = last_arr;
        send(0, 40, 31, 0, "R5");
        send(0, 1, 32, 1, "R6");
        send(1, 1, 33, 0, "R4");
        idle(600);
        chk(rel_at(0, 32) == -1, "R6", "dropped tag never released", rel_at(0, 32), -1);
        chk(rel_at(0, 30) == a + 260, "R5", "first admitted release", rel_at(0, 30), a + 260);
        chk(rel_n[0] == 2, "R5", "admitted count", rel_n[0], 2);
        chk(int'(drop_count) == exp_drops, "R6", "drop count", int'(drop_count), exp_drops);
    endtask

    task automatic t_entries();
        clear_log();
        cfg_buf = 19'd1000; cfg_cpb = 8'd16; cfg_link = 8'd50;
        for (int k = 0; k < DEPTH; k++) send(1, 1, 40 + k, 0, "R7");
        send(1, 1, 48, 1, "R7");
        idle(DEPTH * 51 + 20);
        chk(rel_n[1] == DEPTH, "R7", "slots released", rel_n[1], DEPTH);
        chk(rel_at(1, 48) == -1, "R7", "overflow tag absent", rel_at(1, 48), -1);
    endtask

    task automatic t_same_cycle();
        int a;
        clear_log();
        cfg_buf = 19'd100; cfg_cpb = 8'd16; cfg_link = 8'd0;
        send(0, 100, 50, 0, "R8"); a = last_arr;
        idle(98);
        send(0, 1, 51, 1, "R8");
        send(0, 100, 52, 0, "R8");
        idle(110);
        chk(rel_at(0, 50) == a + 100, "R8", "full packet release", rel_at(0, 50), a + 100);
        chk(rel_at(0, 52) == a + 200, "R8", "reused bytes release", rel_at(0, 52), a + 200);
    endtask

    task automatic t_runtime();
        int a;
        clear_log();
        cfg_buf = 19'd1000; cfg_cpb = 8'd16; cfg_link = 8'd0;
        send(0, 20, 60, 0, "R10"); a = last_arr;
        @(negedge clk); arr_valid = 1'b0; cfg_cpb = 8'd32;
        idle(30);
        chk(rel_at(0, 60) == a + 20, "R10", "held delay unchanged", rel_at(0, 60), a + 20);
        send(0, 20, 61, 0, "R10"); a = last_arr;
        idle(50);
        chk(rel_at(0, 61) == a + 40, "R10", "new rate applied", rel_at(0, 61), a + 40);
        cfg_cpb = 8'd16; cfg_link = 8'd100;
        send(1, 50, 62, 0, "R10");
        @(negedge clk); arr_valid = 1'b0; cfg_buf = 19'd40;
        send(1, 1, 63, 1, "R10");
        idle(200);
        chk(rel_at(1, 63) == -1, "R10", "shrunk budget drop", rel_at(1, 63), -1);
    endtask

    task automatic t_saturate();
        cfg_buf = 19'd0; cfg_link = 8'd0;
        for (int k = 0; k < 260; k++) send(0, 1, 70, 1, "R9");
        idle(3);
        chk(int'(drop_count) == exp_drops, "R9", "saturated count", int'(drop_count), exp_drops);
        chk(drop_count == 8'd255, "R9", "stops at max", int'(drop_count), SAT);
    endtask

    initial begin
        clear_log();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_delay();
        t_fifo();
        t_ports();
        t_bytes();
        t_entries();
        t_same_cycle();
        t_runtime();
        t_saturate();
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        total++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", total, fails);
        $finish;
    end
endmodule